// File: doc/BRIEF.md
# Per-Bunch Occupancy Histogrammer

This block builds a histogram for each monitored trigger input, with one bin per bunch crossing of the machine orbit. An internal crossing counter advances once per clock and restarts when the orbit pulse arrives. Each monitored channel takes one input from the trigger vector through a per-channel lookup and an enable bit. While accumulation is on, a crossing in which that input is high adds one to the channel's bin for the current crossing index. Bins saturate at all ones and do not wrap.

Each bin update is a read-modify-write through a two-stage pipeline into a per-channel memory. When the same bin is hit in two consecutive cycles, the second update takes the first update's result by forwarding, not the stale memory word. To read results, software pauses accumulation and then reads one bin per request, addressed by channel and crossing index. A clear command zeroes every bin by sweeping the crossing addresses. A busy flag is shown during the sweep. Reset starts the same sweep.

Top module: `occ_histo`

## Requirements
- R1: `bx_count` shows the current crossing index. It is 0 after reset and advances by one each cycle. After `ORBIT_LEN-1` (default 3564 crossings, so 0 to 3563) it returns to 0. A cycle with `orbit_in` high makes the next index 0.
- R2: An `orbit_in` pulse in a cycle whose index is not `ORBIT_LEN-1` sets `orbit_err`. The flag stays set until reset. A pulse at index `ORBIT_LEN-1` leaves it clear.
- R3: Channel c monitors `trig_in[sel_map[c*SEL_W +: SEL_W]]` only when `ch_en[c]` is 1. The bins of a disabled channel stay at zero. Several channels may select the same input.
- R4: A crossing is counted only when `acc_en` is 1 and no clear is running in that cycle. In that case, for every monitored channel whose selected input is high, bin (channel, current index) increases by one. No other crossing changes any bin.
- R5: Two updates of the same bin in consecutive cycles both count. This happens when an orbit pulse arrives at index 0.
- R6: A bin at 2^BIN_W-1 (default 30-bit bins) stays at that value when hit again.
- R7: A pulse on `rd_req` is accepted only if `acc_en` was 0 in that cycle and in the two cycles before it, and no clear is running. When accepted, `rd_valid` is 1 in the next cycle and `rd_data` holds bin (`rd_ch`, `rd_addr`). Any other `rd_req` is ignored and `rd_valid` stays 0.
- R8: `clr_req` while idle makes `clr_busy` 1 for exactly `ORBIT_LEN` cycles, starting the next cycle. After the sweep every bin reads 0, and crossings during the sweep are not counted. A `clr_req` during a sweep is ignored.
- R9: During reset and in the first cycle after it, `bx_count` is 0, `orbit_err` is 0 and `rd_valid` is 0. `clr_busy` is 1 because reset starts a full clear sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| orbit_in | input | 1 | Orbit pulse, marks the last crossing of an orbit |
| trig_in | input | NUM_IN | Trigger input vector for this crossing |
| sel_map | input | NUM_CH*SEL_W | Per-channel input index (lookup) |
| ch_en | input | NUM_CH | Per-channel monitor enable |
| acc_en | input | 1 | Accumulation on (1) or paused (0) |
| clr_req | input | 1 | Start a clear sweep |
| rd_req | input | 1 | Bin read request |
| rd_ch | input | CH_W | Channel of the bin to read |
| rd_addr | input | BX_W | Crossing index of the bin to read |
| bx_count | output | BX_W | Current crossing index |
| orbit_err | output | 1 | Sticky misplaced-orbit flag |
| clr_busy | output | 1 | Clear sweep in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | BIN_W | Read bin value |

## Verification
Accumulation and the clear sweep can fall in the same cycle. The bench raises `clr_req` in the middle of a randomly stimulated orbit with accumulation still on, and sends a second request while the sweep runs. A reference model drops every hit from the sweep cycles, and a full read-out afterwards must match it bin by bin. The other overlap is two updates of one bin in back-to-back cycles. The bench provokes it by repeating orbit pulses at index 0, and it is judged by the exact count read from bin 0.

// File: rtl/occ_pkg.sv
package occ_pkg;

    localparam int unsigned BX_PER_ORBIT = 3564;
    localparam int unsigned BIN_BITS     = 30;

    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_e;

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/occ_bxcnt.sv
module occ_bxcnt #(
    parameter int unsigned ORBIT_LEN = 3564,
    parameter int unsigned BX_W      = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            orbit_in,
    output logic [BX_W-1:0] bx,
    output logic            orbit_err
);
    localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bx        <= '0;
            orbit_err <= 1'b0;
        end else if (orbit_in) begin
            bx <= '0;
            if (bx != LAST) orbit_err <= 1'b1;
        end else begin
            bx <= (bx == LAST) ? '0 : bx + 1'b1;
        end
    end

    AST_BX_RANGE: assert property (@(posedge clk) disable iff (rst)
        bx <= LAST);                                              // R1
    AST_ORBIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        orbit_in |=> bx == '0);                                   // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        orbit_err |=> orbit_err);                                 // R2
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(orbit_err) |-> $past(orbit_in));                    // R2

endmodule

// File: rtl/occ_select.sv
module occ_select #(
    parameter int unsigned NUM_IN = 8,
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned SEL_W  = 3
) (
    input  logic [NUM_IN-1:0]       trig_in,
    input  logic [NUM_CH*SEL_W-1:0] sel_map,
    input  logic [NUM_CH-1:0]       ch_en,
    output logic [NUM_CH-1:0]       hit
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SEL_W-1:0] idx;
        assign idx = sel_map[c*SEL_W +: SEL_W];
        always_comb begin
            hit[c] = 1'b0;
            for (int i = 0; i < NUM_IN; i++)
                if (idx == SEL_W'(i)) hit[c] = ch_en[c] & trig_in[i];
        end
    end

endmodule

// File: rtl/occ_bin_ch.sv
module occ_bin_ch #(
    parameter int unsigned ORBIT_LEN = 3564,
    parameter int unsigned BX_W      = 12,
    parameter int unsigned BIN_W     = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BX_W-1:0]  rd_addr,
    input  logic             s2_v,
    input  logic             s2_hit,
    input  logic [BX_W-1:0]  s2_addr,
    input  logic             clr_we,
    input  logic [BX_W-1:0]  clr_addr,
    output logic [BIN_W-1:0] rd_q
);
    logic [BIN_W-1:0] mem [ORBIT_LEN];
    logic [BIN_W-1:0] mem_q, old_val, new_val, wq_data;
    logic [BX_W-1:0]  wq_addr;
    logic             wq_v, acc_we;

    always_comb begin
        old_val = (wq_v && wq_addr == s2_addr) ? wq_data : mem_q;
        new_val = (&old_val) ? old_val : old_val + 1'b1;
        acc_we  = s2_v & s2_hit & ~clr_we;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem[rd_addr];
        if (clr_we)      mem[clr_addr] <= '0;
        else if (acc_we) mem[s2_addr]  <= new_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wq_v    <= 1'b0;
            wq_addr <= '0;
            wq_data <= '0;
        end else begin
            wq_v    <= acc_we;
            wq_addr <= s2_addr;
            wq_data <= new_val;
        end
    end

    assign rd_q = mem_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> new_val != '0);                                // R6
    AST_FWD_SAME_BIN: assert property (@(posedge clk) disable iff (rst)
        (acc_we && wq_v && wq_addr == s2_addr) |-> new_val >= wq_data); // R5

endmodule

// File: rtl/occ_histo.sv
module occ_histo #(
    parameter int unsigned NUM_IN    = 8,
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned ORBIT_LEN = occ_pkg::BX_PER_ORBIT,
    parameter int unsigned BIN_W     = occ_pkg::BIN_BITS,
    localparam int unsigned SEL_W    = occ_pkg::width_of(NUM_IN),
    localparam int unsigned CH_W     = occ_pkg::width_of(NUM_CH),
    localparam int unsigned BX_W     = occ_pkg::width_of(ORBIT_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    orbit_in,
    input  logic [NUM_IN-1:0]       trig_in,
    input  logic [NUM_CH*SEL_W-1:0] sel_map,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic                    acc_en,
    input  logic                    clr_req,
    input  logic                    rd_req,
    input  logic [CH_W-1:0]         rd_ch,
    input  logic [BX_W-1:0]         rd_addr,
    output logic [BX_W-1:0]         bx_count,
    output logic                    orbit_err,
    output logic                    clr_busy,
    output logic                    rd_valid,
    output logic [BIN_W-1:0]        rd_data
);
    import occ_pkg::*;

    localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

    logic [NUM_CH-1:0] hit, s1_hit, s2_hit;
    logic              s1_v, s2_v, rd_ok;
    logic [BX_W-1:0]   s1_addr, s2_addr, raddr, caddr;
    logic [CH_W-1:0]   rd_ch_q;
    logic [BIN_W-1:0]  ch_q [NUM_CH];
    sweep_e            sweep;

    occ_bxcnt #(.ORBIT_LEN(ORBIT_LEN), .BX_W(BX_W)) u_bx (
        .clk(clk), .rst(rst), .orbit_in(orbit_in),
        .bx(bx_count), .orbit_err(orbit_err));

    occ_select #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
        .trig_in(trig_in), .sel_map(sel_map), .ch_en(ch_en), .hit(hit));

    assign clr_busy = (sweep == SWEEP_RUN);

    // Stage 1 samples the crossing, stage 2 performs the update.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0; s1_hit <= '0; s1_addr <= '0;
            s2_v <= 1'b0; s2_hit <= '0; s2_addr <= '0;
        end else begin
            s1_v    <= acc_en & ~clr_busy;
            s1_hit  <= hit;
            s1_addr <= bx_count;
            s2_v    <= s1_v;
            s2_hit  <= s1_hit;
            s2_addr <= s1_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sweep <= SWEEP_RUN;
            caddr <= '0;
        end else if (sweep == SWEEP_RUN) begin
            caddr <= caddr + 1'b1;
            if (caddr == LAST) sweep <= SWEEP_IDLE;
        end else if (clr_req) begin
            sweep <= SWEEP_RUN;
            caddr <= '0;
        end
    end

    assign raddr = s1_v ? s1_addr : rd_addr;
    assign rd_ok = rd_req & ~acc_en & ~s1_v & ~s2_v & ~clr_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_ch_q  <= '0;
        end else begin
            rd_valid <= rd_ok;
            rd_ch_q  <= rd_ch;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bin
        occ_bin_ch #(.ORBIT_LEN(ORBIT_LEN), .BX_W(BX_W), .BIN_W(BIN_W)) u_bin (
            .clk(clk), .rst(rst), .rd_addr(raddr),
            .s2_v(s2_v), .s2_hit(s2_hit[c]), .s2_addr(s2_addr),
            .clr_we(clr_busy), .clr_addr(caddr), .rd_q(ch_q[c]));
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (rd_ch_q == CH_W'(c)) rd_data = ch_q[c];
    end

    AST_RD_PAUSED: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(acc_en));                             // R7
    AST_RD_NOT_IN_CLR: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(clr_busy));                           // R7
    AST_CLR_START: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !clr_busy) |=> clr_busy);                     // R8
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (rst)
        $fell(clr_busy) |-> $past(caddr) == LAST);                // R8

endmodule

// File: tb/occ_histo_test.sv
`timescale 1ns/1ps
module occ_histo_test;
    localparam int NI = 8, NC = 4, L = 24, BW = 4;
    localparam int SW = 3, CW = 2, XW = 5;
    localparam int MAXV = (1 << BW) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic orbit_in = 0, acc_en = 0, clr_req = 0, rd_req = 0;
    logic [NI-1:0] trig_in = '0;
    logic [NC*SW-1:0] sel_map;
    logic [NC-1:0] ch_en = 4'b1011;
    logic [CW-1:0] rd_ch = '0;
    logic [XW-1:0] rd_addr = '0;
    logic [XW-1:0] bx_count;
    logic orbit_err, clr_busy, rd_valid;
    logic [BW-1:0] rd_data;

    int sel [NC] = '{2, 5, 2, 7};
    int mbin [NC][L];
    int mb, busy_cnt, exp_rd, n_chk, n_fail;
    bit merr, a1, a2, exp_rv;
    string exp_tag;

    always #10 clk = ~clk;

    occ_histo #(.NUM_IN(NI), .NUM_CH(NC), .ORBIT_LEN(L), .BIN_W(BW)) uut (
        .clk(clk), .rst(rst), .orbit_in(orbit_in), .trig_in(trig_in),
        .sel_map(sel_map), .ch_en(ch_en), .acc_en(acc_en), .clr_req(clr_req),
        .rd_req(rd_req), .rd_ch(rd_ch), .rd_addr(rd_addr), .bx_count(bx_count),
        .orbit_err(orbit_err), .clr_busy(clr_busy), .rd_valid(rd_valid),
        .rd_data(rd_data));

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs and advance the reference model.
    task automatic apply(bit o, logic [NI-1:0] t, bit acc, bit clr,
                         bit rq, int rch, int raddr, string tag);
        bit bm;
        orbit_in = o; trig_in = t; acc_en = acc; clr_req = clr;
        rd_req = rq; rd_ch = CW'(rch); rd_addr = XW'(raddr);
        bm = (busy_cnt > 0);
        exp_rv = rq && !acc && !a1 && !a2 && !bm;
        if (exp_rv) begin exp_rd = mbin[rch][raddr]; exp_tag = tag; end
        if (acc && !bm)
            for (int c = 0; c < NC; c++)
                if (ch_en[c] && t[sel[c]] && mbin[c][mb] < MAXV) mbin[c][mb]++;
        a2 = a1; a1 = acc && !bm;
        if (busy_cnt > 0) busy_cnt--;
        if (clr && !bm) begin
            for (int c = 0; c < NC; c++)
                for (int a = 0; a < L; a++) mbin[c][a] = 0;
            busy_cnt = L;
        end
        if (o && mb != L-1) merr = 1;
        mb = (o || mb == L-1) ? 0 : mb + 1;
    endtask

    task automatic step(bit o, logic [NI-1:0] t, bit acc, bit clr,
                        bit rq, int rch, int raddr, string tag);
        @(negedge clk);
        chk(bx_count == XW'(mb), "R1 bx_count", int'(bx_count), mb);
        chk(clr_busy == (busy_cnt > 0), "R8 clr_busy", int'(clr_busy), int'(busy_cnt > 0));
        chk(orbit_err == merr, "R2 orbit_err", int'(orbit_err), int'(merr));
        chk(rd_valid == exp_rv, "R7 rd_valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv) chk(int'(rd_data) == exp_rd, exp_tag, int'(rd_data), exp_rd);
        apply(o, t, acc, clr, rq, rch, raddr, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, NI'($urandom), 0, 0, 0, 0, 0, "R4");
    endtask

    task automatic read_all(string tag_all);
        idle(3);
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < L; a++) begin
                string tg;
                tg = (tag_all != "") ? tag_all :
                     (c == 0) ? "R6 saturated bin" :
                     (c == 2) ? "R3 disabled channel" : "R4 bin";
                step(0, NI'($urandom), 0, 0, 1, c, a, tg);
            end
        idle(1);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) sel_map[c*SW +: SW] = SW'(sel[c]);
    end

    initial begin
        void'($urandom(32'd5150));
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < L; a++) mbin[c][a] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bx_count == '0, "R9 reset bx_count", int'(bx_count), 0);
        chk(orbit_err == 1'b0, "R9 reset orbit_err", int'(orbit_err), 0);
        chk(rd_valid == 1'b0, "R9 reset rd_valid", int'(rd_valid), 0);
        chk(clr_busy == 1'b1, "R9 reset clr_busy", int'(clr_busy), 1);
        rst = 0;
        mb = 0; busy_cnt = L; merr = 0; a1 = 0; a2 = 0; exp_rv = 0;
        apply(0, '0, 0, 0, 0, 0, 0, "R9");
        idle(L + 2);

        // Read with accumulation on must be ignored (R7).
        step(mb == L-1, 8'h24, 1, 0, 1, 1, 3, "R7");
        // Directed orbit, then random orbits; ch0 input forced high (R6).
        while (mb != 0) step(mb == L-1, 8'h24, 1, 0, 0, 0, 0, "R4");
        for (int k = 0; k < L; k++) step(mb == L-1, 8'h24, 1, 0, 0, 0, 0, "R4");
        for (int k = 0; k < 19 * L; k++) begin
            logic [NI-1:0] t;
            t = NI'($urandom); t[2] = 1'b1;
            step(mb == L-1, t, 1, 0, 0, 0, 0, "R4");
        end
        // First paused cycle: read too early, ignored (R7).
        step(0, '0, 0, 0, 1, 1, 3, "R7");
        read_all("");

        // Clear in the middle of accumulation, second request ignored (R8).
        for (int k = 0; k < 2 * L + 20; k++)
            step(mb == L-1, NI'($urandom), 1, (k == 30) || (k == 35), 0, 0, 0, "R8");
        read_all("R8 after clear");

        // Same bin updated in consecutive cycles via early orbits (R5, R2).
        while (mb != 0) step(mb == L-1, NI'($urandom), 1, 0, 0, 0, 0, "R5");
        for (int k = 0; k < 3; k++) step(1, 8'h24, 1, 0, 0, 0, 0, "R5");
        for (int k = 0; k < L; k++) step(mb == L-1, 8'h24, 1, 0, 0, 0, 0, "R5");
        read_all("R5 back-to-back");
        chk(orbit_err == 1'b1, "R2 sticky after early orbit", int'(orbit_err), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule